// File: doc/BRIEF.md
# VGA Raster Timing Generator

This block produces the raster timing for an analog VGA monitor from a pixel clock supplied by the caller. Two counters drive all the outputs. One counts pixel clocks along a line. The other counts finished lines through a frame. Each counter is zero on the first visible pixel of its axis, so during display time the counter value is the pixel coordinate. An image source uses the column, row and display-enable outputs to feed colour values to a video DAC. The monitor takes the two sync outputs directly.

Each axis has four segments, visited in a fixed order: visible, front porch, sync, back porch. After the back porch the counter wraps to zero. Every segment length and each sync polarity is an elaboration parameter. The defaults give a 1920x1200 mode at 60 Hz, which needs a pixel clock of 193.16 MHz. All outputs are registered on the same pixel-clock edge. Outside display time the coordinates keep the last visible position. Two control lines to the DAC are tied to fixed levels: blanking is off and sync-on-green is off.

Top module: `vga_raster_gen`

## Requirements
- R1: While rst_ni is low, and at once when it falls (asynchronous), col_o and row_o are 0, disp_en_o is 0, and each sync output is at its inactive level.
- R2: A line lasts H_VIS+H_FP+H_SW+H_BP clocks. hsync_o is active for H_SW consecutive clocks. It becomes active H_VIS+H_FP clocks after the clock that presents column 0.
- R3: A frame lasts V_VIS+V_FP+V_SW+V_BP lines. vsync_o is active for V_SW whole lines, from the start of line V_VIS+V_FP. It changes only in the clock that presents horizontal position 0.
- R4: disp_en_o is 1 exactly when the horizontal position is below H_VIS and the vertical position is below V_VIS. Each visible line gives H_VIS consecutive enabled clocks.
- R5: While disp_en_o is 1, col_o equals the horizontal position and row_o equals the vertical position. Row 0 is the top line and column 0 is the leftmost pixel.
- R6: While disp_en_o is 0, col_o and row_o keep the last displayed position. In horizontal blanking this is H_VIS-1 and the current row. In vertical blanking it is H_VIS-1 and V_VIS-1.
- R7: The sync active level follows H_ACT_HI and V_ACT_HI: 1 gives an active-high pulse and 0 an active-low pulse. The two are set independently.
- R8: dac_blank_n_o is always 1 and dac_sync_n_o is always 0.
- R9: The first clock edge after reset release presents column 0, row 0 with disp_en_o at 1. Every later edge advances the position by one pixel.
- R10: With default parameters, the line is 2592 clocks long, hsync_o is active-low for 208 clocks, and 1920 clocks per line are enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_o | output | 1 | Horizontal sync to the monitor, polarity set by H_ACT_HI |
| vsync_o | output | 1 | Vertical sync to the monitor, polarity set by V_ACT_HI |
| disp_en_o | output | 1 | 1 in display time, 0 in blanking |
| col_o | output | COL_W | Pixel column, 0 is leftmost |
| row_o | output | ROW_W | Pixel row, 0 is top |
| dac_blank_n_o | output | 1 | DAC blanking control, held at 1 |
| dac_sync_n_o | output | 1 | DAC sync-on-green control, held at 0 |

## Verification
Every output is one register stage behind the counters. Edge n after reset release therefore presents raster position n-1, with the line index equal to (n-1) divided by the line length. Horizontal sync becomes active on the edge H_VIS+H_FP after the edge that shows column 0. Vertical sync changes on the same edge as the column-0 pixel of line V_VIS+V_FP. The bench counts edges since release with its own counter, and samples all outputs on the falling clock edge, half a cycle after they settle. Its model maps each edge count to a raster position. Pulse widths and periods are measured as differences between sampled edge indices. An asynchronous reset is checked part-way through a cycle, before the next rising edge.

// File: rtl/vga_raster_pkg.sv
package vga_raster_pkg;

  typedef enum logic [1:0] {
    PH_ACTIVE,
    PH_FRONT,
    PH_SYNC,
    PH_BACK
  } raster_phase_e;

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/raster_axis.sv
module raster_axis
  import vga_raster_pkg::*;
#(
  parameter int VIS   = 1920,
  parameter int FP    = 128,
  parameter int SW    = 208,
  parameter int BP    = 336,
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             vis_o,
  output logic             sync_o,
  output logic             last_o
);

  localparam int TOTAL = VIS + FP + SW + BP;
  localparam logic [CNT_W-1:0] END_ACT = CNT_W'(VIS - 1);
  localparam logic [CNT_W-1:0] END_FP  = CNT_W'(VIS + FP - 1);
  localparam logic [CNT_W-1:0] END_SY  = CNT_W'(VIS + FP + SW - 1);
  localparam logic [CNT_W-1:0] END_BP  = CNT_W'(TOTAL - 1);

  raster_phase_e    phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, seg_end;
  logic             seg_done;

  // segment end lookup keeps the compare to one constant per phase
  always_comb begin
    seg_end = END_ACT;
    phase_d = PH_FRONT;
    case (phase_q)
      PH_ACTIVE: begin seg_end = END_ACT; phase_d = PH_FRONT;  end
      PH_FRONT:  begin seg_end = END_FP;  phase_d = PH_SYNC;   end
      PH_SYNC:   begin seg_end = END_SY;  phase_d = PH_BACK;   end
      PH_BACK:   begin seg_end = END_BP;  phase_d = PH_ACTIVE; end
      default:   begin seg_end = END_ACT; phase_d = PH_FRONT;  end
    endcase
  end

  assign seg_done = (cnt_q == seg_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_ACTIVE;
      cnt_q   <= '0;
    end else if (step_i) begin
      cnt_q <= (seg_done && phase_q == PH_BACK) ? '0 : cnt_q + CNT_W'(1);
      if (seg_done) phase_q <= phase_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign vis_o  = (phase_q == PH_ACTIVE);
  assign sync_o = (phase_q == PH_SYNC);
  assign last_o = (phase_q == PH_BACK) && seg_done;

  assert_phase_cnt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_q == PH_ACTIVE) == (cnt_q <= END_ACT)) &&
    ((phase_q == PH_SYNC) == (cnt_q > END_FP && cnt_q <= END_SY)));

  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && step_i) |=> (cnt_q == '0 && phase_q == PH_ACTIVE));

endmodule

// File: rtl/raster_out_stage.sv
module raster_out_stage #(
  parameter int H_CNT_W  = 12,
  parameter int V_CNT_W  = 11,
  parameter int COL_W    = 11,
  parameter int ROW_W    = 11,
  parameter int H_VIS    = 1920,
  parameter int V_VIS    = 1200,
  parameter bit H_ACT_HI = 1'b0,
  parameter bit V_ACT_HI = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [H_CNT_W-1:0] h_cnt_i,
  input  logic [V_CNT_W-1:0] v_cnt_i,
  input  logic               h_vis_i,
  input  logic               v_vis_i,
  input  logic               h_sync_i,
  input  logic               v_sync_i,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               disp_en_o,
  output logic [COL_W-1:0]   col_o,
  output logic [ROW_W-1:0]   row_o
);

  localparam logic [COL_W-1:0] COL_MAX = COL_W'(H_VIS - 1);
  localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(V_VIS - 1);

  logic disp_d;
  assign disp_d = h_vis_i && v_vis_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o   <= !H_ACT_HI;
      vsync_o   <= !V_ACT_HI;
      disp_en_o <= 1'b0;
      col_o     <= '0;
      row_o     <= '0;
    end else begin
      hsync_o   <= h_sync_i ? H_ACT_HI : !H_ACT_HI;
      vsync_o   <= v_sync_i ? V_ACT_HI : !V_ACT_HI;
      disp_en_o <= disp_d;
      // coordinates freeze during blanking
      if (disp_d) begin
        col_o <= COL_W'(h_cnt_i);
        row_o <= ROW_W'(v_cnt_i);
      end
    end
  end

  assert_col_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_o <= COL_MAX && row_o <= ROW_MAX);

  assert_blank_sync_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_en_o |-> (hsync_o != H_ACT_HI && vsync_o != V_ACT_HI));

  assert_row_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(row_o) |-> (col_o == '0 && disp_en_o));

endmodule

// File: rtl/vga_raster_gen.sv
module vga_raster_gen
  import vga_raster_pkg::*;
#(
  parameter int  H_VIS    = 1920,
  parameter int  H_FP     = 128,
  parameter int  H_SW     = 208,
  parameter int  H_BP     = 336,
  parameter int  V_VIS    = 1200,
  parameter int  V_FP     = 1,
  parameter int  V_SW     = 3,
  parameter int  V_BP     = 38,
  parameter bit  H_ACT_HI = 1'b0,
  parameter bit  V_ACT_HI = 1'b1,
  localparam int COL_W    = cnt_width(H_VIS),
  localparam int ROW_W    = cnt_width(V_VIS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             disp_en_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             dac_blank_n_o,
  output logic             dac_sync_n_o
);

  localparam int H_CNT_W = cnt_width(H_VIS + H_FP + H_SW + H_BP);
  localparam int V_CNT_W = cnt_width(V_VIS + V_FP + V_SW + V_BP);

  logic [H_CNT_W-1:0] h_cnt;
  logic [V_CNT_W-1:0] v_cnt;
  logic h_vis, h_sync, h_last;
  logic v_vis, v_sync, v_last;

  raster_axis #(
    .VIS(H_VIS), .FP(H_FP), .SW(H_SW), .BP(H_BP), .CNT_W(H_CNT_W)
  ) i_h_axis (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (1'b1),
    .cnt_o  (h_cnt),
    .vis_o  (h_vis),
    .sync_o (h_sync),
    .last_o (h_last)
  );

  // vertical axis advances on the last pixel of each line
  raster_axis #(
    .VIS(V_VIS), .FP(V_FP), .SW(V_SW), .BP(V_BP), .CNT_W(V_CNT_W)
  ) i_v_axis (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (h_last),
    .cnt_o  (v_cnt),
    .vis_o  (v_vis),
    .sync_o (v_sync),
    .last_o (v_last)
  );

  raster_out_stage #(
    .H_CNT_W(H_CNT_W), .V_CNT_W(V_CNT_W), .COL_W(COL_W), .ROW_W(ROW_W),
    .H_VIS(H_VIS), .V_VIS(V_VIS), .H_ACT_HI(H_ACT_HI), .V_ACT_HI(V_ACT_HI)
  ) i_out_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .h_cnt_i   (h_cnt),
    .v_cnt_i   (v_cnt),
    .h_vis_i   (h_vis),
    .v_vis_i   (v_vis),
    .h_sync_i  (h_sync),
    .v_sync_i  (v_sync),
    .hsync_o   (hsync_o),
    .vsync_o   (vsync_o),
    .disp_en_o (disp_en_o),
    .col_o     (col_o),
    .row_o     (row_o)
  );

  assign dac_blank_n_o = 1'b1;
  assign dac_sync_n_o  = 1'b0;

  assert_frame_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_last && h_last) |=> (v_cnt == '0 && h_cnt == '0));

endmodule

// File: tb/test_vga_raster_gen.sv
`timescale 1ns/1ps
module test_vga_raster_gen;
  import vga_raster_pkg::*;

  // mode 0: defaults, mode 1: 640x480, mode 2: tiny with opposite polarities
  localparam int HV[3] = '{1920, 640, 20};
  localparam int HF[3] = '{128, 16, 3};
  localparam int HS[3] = '{208, 96, 4};
  localparam int HB[3] = '{336, 48, 5};
  localparam int VV[3] = '{1200, 480, 6};
  localparam int VF[3] = '{1, 10, 2};
  localparam int VS[3] = '{3, 2, 3};
  localparam int VB[3] = '{38, 33, 4};
  localparam int HP[3] = '{0, 0, 1};
  localparam int VP[3] = '{1, 0, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic d_hs, d_vs, d_de, d_bl, d_sy;
  logic [cnt_width(1920)-1:0] d_col;
  logic [cnt_width(1200)-1:0] d_row;
  logic m_hs, m_vs, m_de, m_bl, m_sy;
  logic [cnt_width(640)-1:0] m_col;
  logic [cnt_width(480)-1:0] m_row;
  logic t_hs, t_vs, t_de, t_bl, t_sy;
  logic [cnt_width(20)-1:0] t_col;
  logic [cnt_width(6)-1:0]  t_row;

  vga_raster_gen i_vga_raster_gen (
    .clk_i(clk), .rst_ni(rst_n), .hsync_o(d_hs), .vsync_o(d_vs), .disp_en_o(d_de),
    .col_o(d_col), .row_o(d_row), .dac_blank_n_o(d_bl), .dac_sync_n_o(d_sy));

  vga_raster_gen #(
    .H_VIS(640), .H_FP(16), .H_SW(96), .H_BP(48),
    .V_VIS(480), .V_FP(10), .V_SW(2), .V_BP(33), .H_ACT_HI(1'b0), .V_ACT_HI(1'b0)
  ) i_vga_raster_gen_m640 (
    .clk_i(clk), .rst_ni(rst_n), .hsync_o(m_hs), .vsync_o(m_vs), .disp_en_o(m_de),
    .col_o(m_col), .row_o(m_row), .dac_blank_n_o(m_bl), .dac_sync_n_o(m_sy));

  vga_raster_gen #(
    .H_VIS(20), .H_FP(3), .H_SW(4), .H_BP(5),
    .V_VIS(6), .V_FP(2), .V_SW(3), .V_BP(4), .H_ACT_HI(1'b1), .V_ACT_HI(1'b0)
  ) i_vga_raster_gen_tiny (
    .clk_i(clk), .rst_ni(rst_n), .hsync_o(t_hs), .vsync_o(t_vs), .disp_en_o(t_de),
    .col_o(t_col), .row_o(t_row), .dac_blank_n_o(t_bl), .dac_sync_n_o(t_sy));

  // edges since reset release, cleared asynchronously like the design
  int unsigned k;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) k <= 0;
    else        k <= k + 1;

  int     n_chk = 0;
  int     n_fail = 0;
  bit     done = 1'b0;
  longint cyc = 0;
  int     mon_prev [3][3];
  longint mon_rise [3][3];

  task automatic chk(input string tag, input string what, input int s,
                     input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s mode%0d %s: actual %0d expected %0d", tag, s, what, act, exp);
    end
  endtask

  function automatic void model(input int s, input int unsigned kk,
                                output int e_hs, output int e_vs, output int e_de,
                                output int e_col, output int e_row);
    int ht, vt, p, h, v;
    ht = HV[s] + HF[s] + HS[s] + HB[s];
    vt = VV[s] + VF[s] + VS[s] + VB[s];
    if (kk == 0) begin
      e_hs = 1 - HP[s]; e_vs = 1 - VP[s]; e_de = 0; e_col = 0; e_row = 0;
      return;
    end
    p = int'(kk) - 1;
    h = p % ht;
    v = (p / ht) % vt;
    e_de  = (h < HV[s] && v < VV[s]) ? 1 : 0;
    e_hs  = (h >= HV[s] + HF[s] && h < HV[s] + HF[s] + HS[s]) ? HP[s] : 1 - HP[s];
    e_vs  = (v >= VV[s] + VF[s] && v < VV[s] + VF[s] + VS[s]) ? VP[s] : 1 - VP[s];
    if (v >= VV[s]) begin
      e_col = HV[s] - 1; e_row = VV[s] - 1;
    end else if (h >= HV[s]) begin
      e_col = HV[s] - 1; e_row = v;
    end else begin
      e_col = h; e_row = v;
    end
  endfunction

  function automatic void grab(input int s, output int hs, output int vs, output int de,
                               output int col, output int row, output int bl, output int sy);
    case (s)
      0: begin hs = int'(d_hs); vs = int'(d_vs); de = int'(d_de); col = int'(d_col);
               row = int'(d_row); bl = int'(d_bl); sy = int'(d_sy); end
      1: begin hs = int'(m_hs); vs = int'(m_vs); de = int'(m_de); col = int'(m_col);
               row = int'(m_row); bl = int'(m_bl); sy = int'(m_sy); end
      default: begin hs = int'(t_hs); vs = int'(t_vs); de = int'(t_de); col = int'(t_col);
               row = int'(t_row); bl = int'(t_bl); sy = int'(t_sy); end
    endcase
  endfunction

  task automatic check_all(input int unsigned kk);
    for (int s = 0; s < 3; s++) begin
      int e_hs, e_vs, e_de, e_col, e_row;
      int a_hs, a_vs, a_de, a_col, a_row, a_bl, a_sy;
      int ht, vt;
      string t_h, t_v, t_d, t_c;
      ht = HV[s] + HF[s] + HS[s] + HB[s];
      vt = VV[s] + VF[s] + VS[s] + VB[s];
      model(s, kk, e_hs, e_vs, e_de, e_col, e_row);
      grab(s, a_hs, a_vs, a_de, a_col, a_row, a_bl, a_sy);
      if (kk == 0) begin
        t_h = "R1"; t_v = "R1"; t_d = "R1"; t_c = "R1";
      end else if (kk == 1) begin
        t_h = "R9"; t_v = "R9"; t_d = "R9"; t_c = "R9";
      end else begin
        t_h = (s == 2) ? "R7" : "R2";
        t_v = (s == 2) ? "R7" : "R3";
        t_d = "R4";
        t_c = (e_de != 0) ? "R5" : "R6";
      end
      chk(t_h, "hsync", s, a_hs, e_hs);
      chk(t_v, "vsync", s, a_vs, e_vs);
      chk(t_d, "disp_en", s, a_de, e_de);
      chk(t_c, "col", s, a_col, e_col);
      chk(t_c, "row", s, a_row, e_row);
      chk("R8", "dac_blank_n", s, a_bl, 1);
      chk("R8", "dac_sync_n", s, a_sy, 0);
      // pulse width and period monitors: g0 hsync, g1 vsync, g2 disp_en
      for (int g = 0; g < 3; g++) begin
        int act, wid, gap;
        string tg;
        act = (g == 0) ? int'(a_hs == HP[s]) : (g == 1) ? int'(a_vs == VP[s]) : a_de;
        wid = (g == 0) ? HS[s] : (g == 1) ? VS[s] * ht : HV[s];
        gap = (g == 0) ? ht : (g == 1) ? ht * vt : 0;
        tg  = (g == 1) ? "R3" : (s == 0) ? "R10" : (g == 0) ? "R2" : "R4";
        if (kk == 0) begin
          mon_prev[s][g] = 0;
          mon_rise[s][g] = -1;
        end else begin
          if (act != 0 && mon_prev[s][g] == 0) begin
            if (mon_rise[s][g] >= 0 && gap > 0)
              chk(tg, "period", s, cyc - mon_rise[s][g], gap);
            mon_rise[s][g] = cyc;
          end
          if (act == 0 && mon_prev[s][g] != 0 && mon_rise[s][g] >= 0)
            chk(tg, "active width", s, cyc - mon_rise[s][g], wid);
          mon_prev[s][g] = act;
        end
      end
    end
  endtask

  task automatic cycle_check();
    @(negedge clk);
    cyc++;
    check_all(k);
  endtask

  // reset raised between edges, checked before the next rising edge (R1)
  task automatic async_reset(input int hold);
    @(negedge clk);
    cyc++;
    check_all(k);
    #1 rst_n = 1'b0;
    #0.5 check_all(k);
    repeat (hold) cycle_check();
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h1bad5eed));
    rst_n = 1'b0;
    repeat (3) cycle_check();
    rst_n = 1'b1;
    // directed: two full default lines, many tiny frames, several 640x480 lines
    repeat (2 * 2592 + 300) cycle_check();
    // random reset points and run lengths
    for (int it = 0; it < 25; it++) begin
      async_reset(int'($urandom_range(1, 4)));
      repeat (int'($urandom_range(50, 2000))) cycle_check();
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule